// File: doc/BRIEF.md
# Vendor Margin Command Responder

This block sits on the device side of a serial link lane group. It takes vendor-defined margining commands and acts on them. Each command has a 3-bit margin type, a 3-bit target number and an 8-bit payload. The block adjusts one of four local transmitter settings for the addressed target: launch amplitude, edge slew, pre-cursor emphasis or post-cursor emphasis. It can also start a receiver adaptation run. Each setting lives in a 5-bit register that saturates at both ends.

After each recognized command, the block returns an 8-bit response. The response carries a status code, a flag that reports a clipped step, and the amount that was applied. Receiver adaptation is modelled by a per-target start pulse and a done input. While a run is open, the response reads in-progress.

Transport of the commands and the analog driver both sit outside this block.

Top module: `margin_cmd_responder`

## Requirements
- R1: After reset, every setting of every target holds 16, `resp_o` is 8'h00, and `resp_valid_o` and `adapt_start_o` are 0.
- R2: A strobe on `cmd_valid_i` is acted on only when `margin_type_i` is 3'b101 and `target_i` is between 1 and 5. Any other strobe changes no setting and no response, and does not raise `resp_valid_o`.
- R3: Payload bits [7:5] choose the transmitter setting. 3'b111 is amplitude, 3'b110 slew, 3'b101 pre-emphasis and 3'b100 post-emphasis. Bit 4 set means add and clear means subtract, and bits [3:0] give the step. Target t updates slice [(t-1)*5 +: 5] of the matching `tx_*_o` bus (t=1..5 are transmitters B..F). No setting changes without an accepted command.
- R4: A step that would take a setting above 31 or below 0 leaves it at that limit and sets response bit 4. A step that lands exactly on a limit clears bit 4.
- R5: A transmitter command answers on the next edge with status 3'b000 in bits [7:5], the clip flag in bit 4 and the step amount echoed in bits [3:0]. `resp_valid_o` is high for that one cycle.
- R6: Payload 8'h20 (receiver adaptation) to target t raises `adapt_start_o[t-1]` for exactly one cycle. In that same cycle `resp_o` becomes 8'h40 (in progress).
- R7: While adaptation is in progress, `adapt_done_i[t-1]` for the running target sets `resp_o` to 8'h00 with a one-cycle `resp_valid_o`. Done bits of other targets are ignored.
- R8: While adaptation is in progress, every command is ignored.
- R9: Payload codes 3'b010 and 3'b011 in bits [7:5] produce the NAK response 8'h60 and change no setting.
- R10: Codes 3'b000 and 3'b001 with any of bits [4:0] set produce 8'h60, and no adaptation starts.
- R11: Code 3'b000 with bits [4:0] clear produces response 8'h00 with `resp_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| margin_type_i | input | 3 | Margin type field of the command |
| target_i | input | 3 | Target number, 1..5 |
| payload_i | input | 8 | Command payload: code, direction, amount |
| adapt_done_i | input | 5 | Per-target adaptation finished |
| resp_valid_o | output | 1 | Response updated this cycle |
| resp_o | output | 8 | Status, clip flag, echoed amount |
| adapt_start_o | output | 5 | Per-target adaptation start pulse |
| tx_amp_o | output | 25 | Amplitude setting, 5 bits per target |
| tx_slew_o | output | 25 | Slew setting, 5 bits per target |
| tx_pre_o | output | 25 | Pre-emphasis setting, 5 bits per target |
| tx_post_o | output | 25 | Post-emphasis setting, 5 bits per target |

## Verification
The hardest situation to reach is an open adaptation run that meets other traffic. That traffic is a transmitter command that must be dropped, and a done bit on the wrong target that must not close the run. The stimulus starts a run on one target and holds it open by withholding the matching done bit. During that window it sends a command and a stray done pulse and checks that settings and response are unchanged. It then closes the run and confirms that commands are accepted again. Clipping is reached by chaining steps on one register until it pins at each end, and a separate step lands exactly on the top limit.

// File: rtl/margin_cmd_pkg.sv
package margin_cmd_pkg;

  localparam int TGT_W = 3;
  localparam int AMT_W = 4;
  localparam int NUM_PRM = 4;
  localparam logic [2:0] MTYPE_VENDOR = 3'b101;

  typedef enum logic [2:0] {
    OP_NONE  = 3'b000,
    OP_ADAPT = 3'b001,
    OP_RSV2  = 3'b010,
    OP_RSV3  = 3'b011,
    OP_POST  = 3'b100,
    OP_PRE   = 3'b101,
    OP_SLEW  = 3'b110,
    OP_AMP   = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'b000,
    ST_SETUP = 3'b001,
    ST_BUSY  = 3'b010,
    ST_NAK   = 3'b011
  } stat_e;

  // settings bank index
  typedef enum logic [1:0] {
    PRM_AMP  = 2'd0,
    PRM_SLEW = 2'd1,
    PRM_PRE  = 2'd2,
    PRM_POST = 2'd3
  } prm_e;

  typedef struct packed {
    logic             hit;
    logic             is_tx;
    logic             is_adapt;
    logic             nak;
    prm_e             prm;
    logic             up;
    logic [AMT_W-1:0] amt;
    logic [TGT_W-1:0] lane;
  } dec_t;

endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import margin_cmd_pkg::*;
#(
  parameter int NUM_TGT = 5
) (
  input  logic             cmd_valid_i,
  input  logic [2:0]       margin_type_i,
  input  logic [TGT_W-1:0] target_i,
  input  logic [7:0]       payload_i,
  input  logic             busy_i,
  output dec_t             dec_o
);

  localparam logic [TGT_W-1:0] TGT_MAX = TGT_W'(NUM_TGT);

  op_e  op;
  logic tgt_ok;
  logic args_zero;

  always_comb begin
    op        = op_e'(payload_i[7:5]);
    tgt_ok    = (target_i != '0) && (target_i <= TGT_MAX);
    args_zero = (payload_i[4:0] == 5'd0);

    dec_o          = '0;
    dec_o.hit      = cmd_valid_i && !busy_i && (margin_type_i == MTYPE_VENDOR) && tgt_ok;
    dec_o.lane     = target_i - TGT_W'(1);
    dec_o.up       = payload_i[4];
    dec_o.amt      = payload_i[AMT_W-1:0];
    dec_o.prm      = PRM_AMP;

    unique case (op)
      OP_AMP:   begin dec_o.is_tx = 1'b1; dec_o.prm = PRM_AMP;  end
      OP_SLEW:  begin dec_o.is_tx = 1'b1; dec_o.prm = PRM_SLEW; end
      OP_PRE:   begin dec_o.is_tx = 1'b1; dec_o.prm = PRM_PRE;  end
      OP_POST:  begin dec_o.is_tx = 1'b1; dec_o.prm = PRM_POST; end
      OP_ADAPT: begin
        dec_o.is_adapt = args_zero;
        dec_o.nak      = !args_zero;
      end
      OP_NONE:  dec_o.nak = !args_zero;
      OP_RSV2, OP_RSV3: dec_o.nak = 1'b1;
      default:  dec_o.nak = 1'b1;
    endcase
  end

endmodule

// File: rtl/mc_sat_step.sv
module mc_sat_step #(
  parameter int W     = 5,
  parameter int AMT_W = 4
) (
  input  logic [W-1:0]     cur_i,
  input  logic             up_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     nxt_o,
  output logic             clip_o
);

  localparam logic [W:0] LIM = {1'b0, {W{1'b1}}};

  logic [W:0] amt_x;
  logic [W:0] sum;
  logic [W:0] dif;

  always_comb begin
    amt_x = {{(W+1-AMT_W){1'b0}}, amt_i};
    sum   = {1'b0, cur_i} + amt_x;
    dif   = {1'b0, cur_i} - amt_x;
    if (up_i) begin
      clip_o = (sum > LIM);
      nxt_o  = clip_o ? {W{1'b1}} : sum[W-1:0];
    end else begin
      clip_o = dif[W];  // borrow out
      nxt_o  = clip_o ? '0 : dif[W-1:0];
    end
  end

endmodule

// File: rtl/mc_tx_bank.sv
module mc_tx_bank
  import margin_cmd_pkg::*;
#(
  parameter int NUM_TGT = 5,
  parameter int W       = 5,
  parameter int RST_VAL = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [TGT_W-1:0]   lane_i,
  input  prm_e               prm_i,
  input  logic               up_i,
  input  logic [AMT_W-1:0]   amt_i,
  output logic               clip_o,
  output logic [NUM_TGT*W-1:0] amp_o,
  output logic [NUM_TGT*W-1:0] slew_o,
  output logic [NUM_TGT*W-1:0] pre_o,
  output logic [NUM_TGT*W-1:0] post_o
);

  logic [W-1:0] set_q [NUM_PRM][NUM_TGT];
  logic [W-1:0] cur;
  logic [W-1:0] nxt;

  always_comb begin
    cur = '0;
    for (int p = 0; p < NUM_PRM; p++) begin
      for (int l = 0; l < NUM_TGT; l++) begin
        if (prm_i == prm_e'(p) && lane_i == TGT_W'(l)) cur = set_q[p][l];
      end
    end
  end

  mc_sat_step #(.W(W), .AMT_W(AMT_W)) u_step (
    .cur_i  (cur),
    .up_i   (up_i),
    .amt_i  (amt_i),
    .nxt_o  (nxt),
    .clip_o (clip_o)
  );

  for (genvar p = 0; p < NUM_PRM; p++) begin : g_prm
    for (genvar l = 0; l < NUM_TGT; l++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          set_q[p][l] <= W'(RST_VAL);
        end else if (we_i && prm_i == prm_e'(p) && lane_i == TGT_W'(l)) begin
          set_q[p][l] <= nxt;
        end
      end
    end
  end

  for (genvar l = 0; l < NUM_TGT; l++) begin : g_out
    assign amp_o [l*W +: W] = set_q[PRM_AMP][l];
    assign slew_o[l*W +: W] = set_q[PRM_SLEW][l];
    assign pre_o [l*W +: W] = set_q[PRM_PRE][l];
    assign post_o[l*W +: W] = set_q[PRM_POST][l];
  end

endmodule

// File: rtl/mc_adapt_ctrl.sv
module mc_adapt_ctrl
  import margin_cmd_pkg::*;
#(
  parameter int NUM_TGT = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [TGT_W-1:0]   lane_i,
  input  logic [NUM_TGT-1:0] done_i,
  output logic [NUM_TGT-1:0] start_o,
  output logic               busy_o,
  output logic               fin_o
);

  logic [TGT_W-1:0] lane_q;
  logic             done_sel;

  always_comb begin
    done_sel = 1'b0;
    for (int l = 0; l < NUM_TGT; l++) begin
      if (lane_q == TGT_W'(l)) done_sel = done_i[l];
    end
    fin_o = busy_o && done_sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      lane_q  <= '0;
      start_o <= '0;
    end else begin
      start_o <= '0;
      if (go_i) begin
        busy_o <= 1'b1;
        lane_q <= lane_i;
        for (int l = 0; l < NUM_TGT; l++) begin
          if (lane_i == TGT_W'(l)) start_o[l] <= 1'b1;
        end
      end else if (fin_o) begin
        busy_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/margin_cmd_responder.sv
module margin_cmd_responder
  import margin_cmd_pkg::*;
#(
  parameter int NUM_TGT = 5,
  parameter int W       = 5,
  parameter int RST_VAL = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           margin_type_i,
  input  logic [2:0]           target_i,
  input  logic [7:0]           payload_i,
  input  logic [NUM_TGT-1:0]   adapt_done_i,
  output logic                 resp_valid_o,
  output logic [7:0]           resp_o,
  output logic [NUM_TGT-1:0]   adapt_start_o,
  output logic [NUM_TGT*W-1:0] tx_amp_o,
  output logic [NUM_TGT*W-1:0] tx_slew_o,
  output logic [NUM_TGT*W-1:0] tx_pre_o,
  output logic [NUM_TGT*W-1:0] tx_post_o
);

  dec_t dec;
  logic adapt_busy;
  logic adapt_fin;
  logic clip;
  logic [7:0] resp_d;

  mc_decode #(.NUM_TGT(NUM_TGT)) u_dec (
    .cmd_valid_i   (cmd_valid_i),
    .margin_type_i (margin_type_i),
    .target_i      (target_i),
    .payload_i     (payload_i),
    .busy_i        (adapt_busy),
    .dec_o         (dec)
  );

  mc_tx_bank #(.NUM_TGT(NUM_TGT), .W(W), .RST_VAL(RST_VAL)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (dec.hit && dec.is_tx),
    .lane_i (dec.lane),
    .prm_i  (dec.prm),
    .up_i   (dec.up),
    .amt_i  (dec.amt),
    .clip_o (clip),
    .amp_o  (tx_amp_o),
    .slew_o (tx_slew_o),
    .pre_o  (tx_pre_o),
    .post_o (tx_post_o)
  );

  mc_adapt_ctrl #(.NUM_TGT(NUM_TGT)) u_adapt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (dec.hit && dec.is_adapt),
    .lane_i  (dec.lane),
    .done_i  (adapt_done_i),
    .start_o (adapt_start_o),
    .busy_o  (adapt_busy),
    .fin_o   (adapt_fin)
  );

  always_comb begin
    if (dec.nak)           resp_d = {ST_NAK, 5'd0};
    else if (dec.is_tx)    resp_d = {ST_IDLE, clip, dec.amt};
    else if (dec.is_adapt) resp_d = {ST_BUSY, 5'd0};
    else                   resp_d = {ST_IDLE, 5'd0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_o       <= '0;
      resp_valid_o <= 1'b0;
    end else if (dec.hit) begin
      resp_o       <= resp_d;
      resp_valid_o <= 1'b1;
    end else if (adapt_fin) begin
      resp_o       <= {ST_IDLE, 5'd0};
      resp_valid_o <= 1'b1;
    end else begin
      resp_valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/margin_cmd_responder_chk.sv
module margin_cmd_responder_chk #(
  parameter int NUM_TGT = 5,
  parameter int W       = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_valid_i,
  input logic [2:0]           margin_type_i,
  input logic [2:0]           target_i,
  input logic [7:0]           payload_i,
  input logic [NUM_TGT-1:0]   adapt_done_i,
  input logic                 resp_valid_o,
  input logic [7:0]           resp_o,
  input logic [NUM_TGT-1:0]   adapt_start_o,
  input logic [NUM_TGT*W-1:0] tx_amp_o,
  input logic                 adapt_busy
);

  localparam logic [2:0] TGT_MAX = 3'(NUM_TGT);

  logic acc;
  assign acc = cmd_valid_i && !adapt_busy && margin_type_i == 3'b101 &&
               target_i != 3'd0 && target_i <= TGT_MAX;

  // R2
  foreign_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && margin_type_i != 3'b101 && !(|adapt_done_i) |=> !resp_valid_o);

  // R6
  start_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(adapt_start_o));

  // R6
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |adapt_start_o |-> resp_o == 8'h40 && resp_valid_o);

  // R9
  reserved_nak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && payload_i[7:6] == 2'b01 |=> resp_o == 8'h60 && resp_valid_o);

  // R5
  echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && payload_i[7] |=> resp_o[3:0] == $past(payload_i[3:0]) && resp_o[7:5] == 3'b000);

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adapt_busy && !(|adapt_done_i) |=> $stable(resp_o) && $stable(tx_amp_o));

  // R3
  amp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(tx_amp_o));

endmodule

bind margin_cmd_responder margin_cmd_responder_chk #(.NUM_TGT(NUM_TGT), .W(W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_valid_i   (cmd_valid_i),
  .margin_type_i (margin_type_i),
  .target_i      (target_i),
  .payload_i     (payload_i),
  .adapt_done_i  (adapt_done_i),
  .resp_valid_o  (resp_valid_o),
  .resp_o        (resp_o),
  .adapt_start_o (adapt_start_o),
  .tx_amp_o      (tx_amp_o),
  .adapt_busy    (adapt_busy)
);

// File: tb/tb_margin_cmd_responder.sv
module tb_margin_cmd_responder;

  localparam int NT = 5;
  localparam int W  = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic [2:0]      mtype = '0;
  logic [2:0]      tgt = '0;
  logic [7:0]      pay = '0;
  logic [NT-1:0]   done = '0;
  logic            rvalid;
  logic [7:0]      resp;
  logic [NT-1:0]   start;
  logic [NT*W-1:0] amp, slew, pre, post;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  margin_cmd_responder dut (
    .clk_i (clk), .rst_ni (rst_n), .cmd_valid_i (cmd_valid),
    .margin_type_i (mtype), .target_i (tgt), .payload_i (pay),
    .adapt_done_i (done), .resp_valid_o (rvalid), .resp_o (resp),
    .adapt_start_o (start), .tx_amp_o (amp), .tx_slew_o (slew),
    .tx_pre_o (pre), .tx_post_o (post)
  );

  typedef struct packed {
    logic [2:0] mt;
    logic [2:0] tg;
    logic [7:0] pl;
    logic       ev;
    logic [7:0] er;
    logic [1:0] sel;
    logic [2:0] idx;
    logic [4:0] val;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{3'b101, 3'd1, 8'hF5, 1'b1, 8'h05, 2'd0, 3'd0, 5'd21}, // R3 amp up 5
    '{3'b101, 3'd1, 8'hFF, 1'b1, 8'h1F, 2'd0, 3'd0, 5'd31}, // R4 clip high
    '{3'b101, 3'd1, 8'hE3, 1'b1, 8'h03, 2'd0, 3'd0, 5'd28}, // R3 amp down
    '{3'b101, 3'd2, 8'hDA, 1'b1, 8'h0A, 2'd1, 3'd1, 5'd26}, // R3 slew
    '{3'b101, 3'd3, 8'hA9, 1'b1, 8'h09, 2'd2, 3'd2, 5'd7 }, // R3 pre
    '{3'b101, 3'd3, 8'hAF, 1'b1, 8'h1F, 2'd2, 3'd2, 5'd0 }, // R4 clip low
    '{3'b101, 3'd5, 8'h9C, 1'b1, 8'h0C, 2'd3, 3'd4, 5'd28}, // R3 post tgt F
    '{3'b100, 3'd1, 8'hF5, 1'b0, 8'h0C, 2'd0, 3'd0, 5'd28}, // R2 wrong type
    '{3'b101, 3'd6, 8'hF5, 1'b0, 8'h0C, 2'd0, 3'd0, 5'd28}, // R2 tgt 6
    '{3'b101, 3'd0, 8'hF5, 1'b0, 8'h0C, 2'd0, 3'd0, 5'd28}, // R2 tgt 0
    '{3'b101, 3'd2, 8'h47, 1'b1, 8'h60, 2'd1, 3'd1, 5'd26}, // R9 code 010
    '{3'b101, 3'd2, 8'h60, 1'b1, 8'h60, 2'd1, 3'd1, 5'd26}, // R9 code 011
    '{3'b101, 3'd4, 8'h01, 1'b1, 8'h60, 2'd3, 3'd3, 5'd16}, // R10 nop amt
    '{3'b101, 3'd4, 8'h00, 1'b1, 8'h00, 2'd3, 3'd3, 5'd16}, // R11 nop
    '{3'b101, 3'd4, 8'h30, 1'b1, 8'h60, 2'd3, 3'd3, 5'd16}, // R10 adapt dir
    '{3'b101, 3'd1, 8'hE0, 1'b1, 8'h00, 2'd0, 3'd0, 5'd28}  // R5 zero step
  };

  function automatic logic [4:0] get_set(input int sel, input int idx);
    case (sel)
      0: return amp[idx*W +: W];
      1: return slew[idx*W +: W];
      2: return pre[idx*W +: W];
      default: return post[idx*W +: W];
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive at negedge; outputs of the capturing edge are visible at the following negedge
  task automatic send(input logic [2:0] mt, input logic [2:0] tg, input logic [7:0] pl);
    @(negedge clk);
    cmd_valid = 1'b1; mtype = mt; tgt = tg; pay = pl;
    @(negedge clk);
    cmd_valid = 1'b0; mtype = '0; tgt = '0; pay = '0;
  endtask

  task automatic pulse_done(input logic [NT-1:0] d);
    @(negedge clk);
    done = d;
    @(negedge clk);
    done = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 amp", 32'(amp), 32'({NT{5'd16}}));
    chk("R1 slew", 32'(slew), 32'({NT{5'd16}}));
    chk("R1 pre", 32'(pre), 32'({NT{5'd16}}));
    chk("R1 post", 32'(post), 32'({NT{5'd16}}));
    chk("R1 resp", 32'(resp), 32'h00);
    chk("R1 valid", 32'(rvalid), 0);
    chk("R1 start", 32'(start), 0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].mt, VEC[i].tg, VEC[i].pl);
      chk($sformatf("R2/R5 valid v%0d", i), 32'(rvalid), 32'(VEC[i].ev));
      chk($sformatf("R5/R9 resp v%0d", i), 32'(resp), 32'(VEC[i].er));
      chk($sformatf("R3/R4 set v%0d", i), 32'(get_set(VEC[i].sel, VEC[i].idx)), 32'(VEC[i].val));
      chk($sformatf("R10 start v%0d", i), 32'(start), 0);
    end

    // R6 adaptation on target 3
    send(3'b101, 3'd3, 8'h20);
    chk("R6 start", 32'(start), 32'b00100);
    chk("R6 resp", 32'(resp), 32'h40);
    chk("R6 valid", 32'(rvalid), 1);
    @(negedge clk);
    chk("R6 start one cycle", 32'(start), 0);

    // R8 command dropped while busy
    send(3'b101, 3'd1, 8'hF1);
    chk("R8 amp held", 32'(get_set(0, 0)), 28);
    chk("R8 resp held", 32'(resp), 32'h40);
    chk("R8 no valid", 32'(rvalid), 0);

    // R7 wrong-lane done ignored
    pulse_done(5'b00001);
    chk("R7 stray done", 32'(resp), 32'h40);
    chk("R7 stray valid", 32'(rvalid), 0);

    pulse_done(5'b00100);
    chk("R7 finish resp", 32'(resp), 32'h00);
    chk("R7 finish valid", 32'(rvalid), 1);

    // accepted again after finish
    send(3'b101, 3'd1, 8'hF1);
    chk("R8 resume amp", 32'(get_set(0, 0)), 29);
    chk("R5 resume resp", 32'(resp), 32'h01);

    // R4 exact limit is not a clip
    send(3'b101, 3'd5, 8'hFF);
    chk("R4 exact amp", 32'(get_set(0, 4)), 31);
    chk("R4 exact resp", 32'(resp), 32'h0F);
    send(3'b101, 3'd5, 8'hF1);
    chk("R4 over amp", 32'(get_set(0, 4)), 31);
    chk("R4 over resp", 32'(resp), 32'h11);
    send(3'b101, 3'd3, 8'hA0);
    chk("R4 zero at floor", 32'(get_set(2, 2)), 0);
    chk("R4 zero at floor resp", 32'(resp), 32'h00);

    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule